// File: doc/BRIEF.md
# Stipple and Block-Transfer Drawing Engine

This engine draws into an 8-bit-per-pixel framebuffer over a byte-wide memory port. The host issues each command as two 32-bit bus writes. A write whose address has bit 2 clear only loads a colour word. A write whose address has bit 2 set starts an operation. The destination pixel is taken from address bits 22:3 of that second write.

A mode input selects how the data word of the starting write is read. In stipple mode the word is a 32-pixel mask, and each set bit paints the latched colour. In blit mode the word holds a source pixel address and a run length. A source of all ones asks for a fill with the latched colour. Any other source asks for a copy, which runs in ascending address order, one read and then one write per byte.

While an operation runs, the engine holds `bus_ready` low. Further host writes wait and are not lost. A one-cycle `done` pulse marks the end of each operation.

Top module: `stip_blit_engine`

## Requirements
- R1: A write with address bit 2 = 0 loads the colour register. It starts no operation and makes no memory access. Only the colour's low byte (bits 7:0) is ever drawn.
- R2: A write with address bit 2 = 1 and `bus_ready` high starts an operation. The destination pixel is byte address bits 22:3, which is `bus_addr[22:3]`.
- R3: Stipple (`bus_blit`=0): mask bit 31 maps to destination+0 and bit 0 maps to destination+31. Every set bit writes the colour's low byte to its pixel.
- R4: Stipple: a pixel whose mask bit is clear keeps its previous value.
- R5: A stipple keeps `busy` high for exactly 32 cycles, whatever the mask holds.
- R6: Blit (`bus_blit`=1): the source is data bits 23:0 and the length is data bits 28:24 plus 1, giving 1 to 32 pixels. Bits 31:29 are ignored. A source of 0xFFFFFF fills the run with the colour's low byte, one pixel per cycle, so `busy` stays high for the length in cycles.
- R7: Blit with any other source copies the run one byte at a time in ascending order, a read cycle then a write cycle. `busy` stays high for twice the length. When the destination overlaps ahead of the source, bytes already copied are read again.
- R8: `bus_rdata` is always zero.
- R9: `bus_ready` is low while `busy` is high. A host write held during that time is accepted once the engine is idle, and it takes effect.
- R10: `done` is high for exactly one cycle: the first cycle after the final pixel slot of an operation, when `busy` has just dropped.
- R11: After reset the engine is idle: `busy`=0, `bus_ready`=1, `done`=0, and no memory read or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write request, held until accepted |
| bus_addr | input | 21 | Host byte address bits 22:2 |
| bus_wdata | input | 32 | Host write data |
| bus_blit | input | 1 | Operation select: 0 stipple, 1 blit |
| bus_ready | output | 1 | Host write accepted on this edge when high |
| bus_rdata | output | 32 | Host read data, always zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_addr | output | 24 | Framebuffer pixel address |
| mem_we | output | 1 | Framebuffer byte write |
| mem_re | output | 1 | Framebuffer byte read, data valid next cycle |
| mem_wdata | output | 8 | Framebuffer write data |
| mem_rdata | input | 8 | Framebuffer read data |

## Verification
The hardest case to reach from the ports is a host write that arrives while an operation is still running. The bench creates it by issuing a colour load straight after a stipple starts, without waiting for `done`. It counts the cycles for which `bus_ready` holds that write back. It then checks that the running stipple still paints the old colour and that the next operation uses the new one. An overlapping copy, with the destination one pixel past the source, is also run. It shows the ascending order, because it smears the first source byte across the whole run.

// File: rtl/stip_blit_engine.sv
module stip_blit_engine #(
  parameter int PIX_W  = 24,
  parameter int DST_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [DST_W+2:2]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_blit,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic [PIX_W-1:0]  mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int CNT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {K_STIP, K_FILL, K_COPY} kind_t;

  kind_t             kind;
  logic              rd_phase;
  logic [CNT_W-1:0]  cnt, last;
  logic [PIX_W-1:0]  dst, src;
  logic [DATA_W-1:0] mask;
  logic [7:0]        color;

  wire accept    = bus_wr && !busy;
  wire start     = accept && bus_addr[2];
  wire step_end  = busy && (kind != K_COPY || rd_phase);
  wire last_step = step_end && (cnt == last);

  assign bus_ready = !busy;
  assign bus_rdata = '0;

  assign mem_re    = busy && kind == K_COPY && !rd_phase;
  assign mem_we    = busy && ((kind == K_STIP) ? mask[DATA_W-1] :
                              (kind == K_FILL) ? 1'b1 : rd_phase);
  assign mem_addr  = (mem_re ? src : dst) + PIX_W'(cnt);
  assign mem_wdata = (kind == K_COPY) ? mem_rdata : color;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      kind     <= K_STIP;
      rd_phase <= 1'b0;
      cnt      <= '0;
      last     <= '0;
      dst      <= '0;
      src      <= '0;
      mask     <= '0;
      color    <= '0;
    end else begin
      done <= last_step;
      if (accept && !bus_addr[2]) color <= bus_wdata[7:0];
      if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        rd_phase <= 1'b0;
        dst      <= PIX_W'(bus_addr[DST_W+2:3]);
        mask     <= bus_wdata;
        src      <= bus_wdata[PIX_W-1:0];
        if (!bus_blit) begin
          kind <= K_STIP;
          last <= '1;
        end else begin
          kind <= (bus_wdata[PIX_W-1:0] == '1) ? K_FILL : K_COPY;
          last <= bus_wdata[PIX_W +: CNT_W];
        end
      end else if (busy) begin
        if (kind == K_COPY) rd_phase <= !rd_phase;
        if (step_end) begin
          cnt  <= cnt + 1'b1;
          mask <= mask << 1;
          if (cnt == last) busy <= 1'b0;
        end
      end
    end
  end

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && bus_addr[2]) |=> busy);

  assert_latch_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && !bus_addr[2]) |=> !busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_rw_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_copy_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);
endmodule

// File: tb/test_stip_blit_engine.sv
module test_stip_blit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N = 4096;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [22:2] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_blit = 0;
  logic        bus_ready, busy, done, mem_we, mem_re;
  logic [31:0] bus_rdata;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  logic [7:0] mem [MEM_N];
  logic [7:0] exp_mem [MEM_N];
  int checks = 0, fails = 0, stall_cycles = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stip_blit_engine i_stip_blit_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_blit(bus_blit), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_mem(input string req, input string what);
    int bad = -1;
    for (int i = 0; i < MEM_N; i++)
      if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1, req, what, 0, 0);
    else check(0, req, {what, " pixel"}, mem[bad], exp_mem[bad]);
  endtask

  task automatic bus_write(input logic [22:0] a, input logic [31:0] d, input logic blit);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[22:2]; bus_wdata = d; bus_blit = blit;
    stall_cycles = 0;
    while (!bus_ready) begin stall_cycles++; @(negedge clk); end
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic run_op(input int exp_cycles, input string req);
    int n = 0;
    int done_seen = 0;
    while (busy && n < 200) begin
      if (done) done_seen++;
      check(bus_rdata == 0, "R8", "read data while busy", bus_rdata, 0);
      check(!bus_ready, "R9", "ready while busy", bus_ready, 0);
      n++;
      @(negedge clk);
    end
    check(n == exp_cycles, req, "busy cycles", n, exp_cycles);
    check(done == 1 && done_seen == 0, "R10", "done after busy", done, 1);
    @(negedge clk);
    check(done == 0, "R10", "done one cycle", done, 0);
  endtask

  function automatic logic [22:0] dst_addr(input int d);
    return 23'((d << 3) | 4);
  endfunction

  task automatic t_reset;
    check(busy == 0, "R11", "busy at reset", busy, 0);
    check(bus_ready == 1, "R11", "ready at reset", bus_ready, 1);
    check(done == 0, "R11", "done at reset", done, 0);
    check(!mem_we && !mem_re, "R11", "mem access at reset", {mem_we, mem_re}, 0);
    check(bus_rdata == 0, "R8", "read data idle", bus_rdata, 0);
  endtask

  task automatic t_stipple;
    logic [31:0] m = 32'h80F0_0A01;
    int d = 12'h345;
    bus_write(23'h0, 32'hABCD_EF5A, 0);
    check(busy == 0, "R1", "latch starts nothing", busy, 0);
    check_mem("R1", "latch leaves memory");
    bus_write(dst_addr(d), m, 0);
    for (int i = 0; i < 32; i++) if (m[31-i]) exp_mem[d+i] = 8'h5A;
    run_op(32, "R5");
    check_mem("R3", "stipple set bits and placement R2");
    check(mem[d+1] == exp_mem[d+1], "R4", "clear bit unchanged", mem[d+1], exp_mem[d+1]);
    bus_write(dst_addr(d + 64), 32'h0, 0);
    run_op(32, "R5");
    check_mem("R4", "empty mask writes nothing");
  endtask

  task automatic t_fill;
    bus_write(23'h0, 32'h0000_00C3, 0);
    bus_write(dst_addr(12'h500), {3'b111, 5'd0, 24'hFFFFFF}, 1);
    exp_mem[12'h500] = 8'hC3;
    run_op(1, "R6");
    check_mem("R6", "fill length 1");
    bus_write(dst_addr(12'h600), {3'b000, 5'd31, 24'hFFFFFF}, 1);
    for (int i = 0; i < 32; i++) exp_mem[12'h600 + i] = 8'hC3;
    run_op(32, "R6");
    check_mem("R6", "fill length 32");
  endtask

  task automatic t_copy;
    bus_write(dst_addr(12'h700), {3'b000, 5'd7, 24'h000345}, 1);
    for (int i = 0; i < 8; i++) exp_mem[12'h700 + i] = exp_mem[12'h345 + i];
    run_op(16, "R7");
    check_mem("R7", "copy 8 bytes");
    bus_write(dst_addr(12'h801), {3'b000, 5'd4, 24'h000800}, 1);
    for (int i = 0; i < 5; i++) exp_mem[12'h801 + i] = exp_mem[12'h800 + i];
    run_op(10, "R7");
    check_mem("R7", "overlap copy ascending");
  endtask

  task automatic t_stall;
    bus_write(23'h0, 32'h0000_0011, 0);
    bus_write(dst_addr(12'h900), 32'hFFFF_FFFF, 0);
    bus_write(23'h0, 32'h0000_0022, 0);
    check(stall_cycles > 0, "R9", "colour write stalled", stall_cycles, 1);
    for (int i = 0; i < 32; i++) exp_mem[12'h900 + i] = 8'h11;
    check_mem("R9", "running stipple keeps old colour");
    bus_write(dst_addr(12'hA00), {3'b000, 5'd3, 24'hFFFFFF}, 1);
    for (int i = 0; i < 4; i++) exp_mem[12'hA00 + i] = 8'h22;
    run_op(4, "R6");
    check_mem("R9", "stalled write took effect");
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'((i * 7) ^ (i >> 3));
      exp_mem[i] = 8'((i * 7) ^ (i >> 3));
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_stipple;
    t_fill;
    t_copy;
    t_stall;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule